// File: doc/BRIEF.md
# Packetized Block Write Sender

This engine sits on the host side of a serial byte link. It sends the payload of a block write once the preceding write command has been accepted. A single `start` pulse latches the total payload length, a packet-size select and a CRC enable. The engine pulls payload bytes from a ready/valid input stream and cuts them into fixed-size packets. Each packet is preceded by a tag byte that gives its position in the transfer. When enabled, each packet is followed by a two-byte CRC computed over that packet alone. The output is a ready/valid byte stream for the serializer.

Replies to the earlier packets are not awaited. Once the final packet has gone out, the engine takes four reply bytes. It searches them from the back for the final packet's reply start, judges that reply, and ends with a one-cycle `done` pulse and a two-bit status. A payload that is too short is refused at once, and nothing is sent.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_TAG`: sends the tag byte.
- `ST_DATA`: passes payload bytes through.
- `ST_CRC_HI` and `ST_CRC_LO`: send the CRC.
- `ST_COLLECT`: takes the four reply bytes.
- `ST_EVAL`: judges the reply.
- `ST_REPORT`: raises `done`.

The transitions are:
- From `ST_IDLE`: on `start`, go to `ST_REPORT` if the payload is too short, otherwise to `ST_TAG`.
- From `ST_TAG`: go to `ST_DATA` when the tag is accepted.
- From `ST_DATA`: after the packet's last byte, go to `ST_CRC_HI` when the CRC is on. When it is off, go to `ST_TAG` if more packets remain, or to `ST_COLLECT` after the final packet.
- From `ST_CRC_HI`: go to `ST_CRC_LO`.
- From `ST_CRC_LO`: go to `ST_TAG` if more packets remain, otherwise to `ST_COLLECT`.
- From `ST_COLLECT`: go to `ST_EVAL` after the fourth reply byte.
- From `ST_EVAL`: go to `ST_REPORT`.
- From `ST_REPORT`: go to `ST_IDLE`.

Top module: `pkt_block_sender`

## Requirements
- R1: The packet size is 256 << `pkt_sel` bytes. Any `pkt_sel` above 5 is treated as 5 (8192 bytes). Every packet is full size except the final one, which carries the remainder. Exactly `total_len` payload bytes are consumed.
- R2: Each packet begins with a tag byte of 0xF0 OR an order code. The code is 1 for the first of several packets, 2 for an inner packet, and 3 for the final packet or the only packet.
- R3: With `crc_en` set, each packet's payload is followed by two bytes, high byte first. They hold a CRC-16 with polynomial 0x1021, MSB-first and unreflected. The CRC is seeded with 0xFFFF at every packet and covers only that packet's payload bytes.
- R4: With `crc_en` clear, no CRC bytes are emitted. Each tag is followed directly by its payload.
- R5: `rx_ready` is raised only after the final packet's last byte has left. Exactly four reply bytes are taken, and they are numbered 0 to 3 in arrival order.
- R6: The reply bytes are scanned at indices 2, 1 and 0, in that order. The first byte whose upper nibble is 0xC is the reply start. The status is 0 (success) if that byte's lower nibble is 3 and the byte after it is 0x00.
- R7: If `total_len` is below 5 when `start` arrives, the engine raises `done` in the next cycle with status 1. It emits no byte and consumes no input.
- R8: If none of the scanned bytes has upper nibble 0xC, the status is 2. If the reply start is found but is bad, the status is 3.
- R9: A `start` pulse while a transfer is in progress has no effect on the output stream or the result.
- R10: Stalls on `tx_ready`, `in_valid` or `rx_valid` do not change the byte sequence or the result. While a non-payload byte is stalled, it is held stable.
- R11: `done` is a single-cycle pulse. The engine is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| total_len | input | LEN_W | Payload length in bytes |
| pkt_sel | input | SEL_W | Packet size select, size = 256 << min(pkt_sel,5) |
| crc_en | input | 1 | Append CRC-16 to each packet |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle when valid |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Serializer accepts the outgoing byte |
| rx_valid | input | 1 | Reply byte available |
| rx_data | input | 8 | Reply byte |
| rx_ready | output | 1 | Engine takes a reply byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 success, 1 too short, 2 no reply start, 3 bad reply |

## Verification
The hardest case to reach is a reply window that holds more than one start-nibble byte: leftover bytes from an earlier packet's reply sit in front of the final one. The backward search must choose the later byte even when the earlier one looks like a good reply. The bench builds such windows directly. Examples are a stale inner-packet reply ahead of a good one, and a good reply ahead of a bad later one. It also mixes in fully random windows. The transfer lengths sit on and around packet boundaries, and random stalls on all three streams exercise the hand-offs between tag, payload and CRC.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_COLLECT,
        ST_EVAL,
        ST_REPORT
    } pbs_state_e;

    typedef enum logic [1:0] {
        STAT_OK       = 2'd0,
        STAT_SHORT    = 2'd1,
        STAT_NO_START = 2'd2,
        STAT_BAD_RSP  = 2'd3
    } pbs_status_e;

    localparam logic [3:0]  TAG_NIBBLE  = 4'hF;
    localparam logic [3:0]  RSP_NIBBLE  = 4'hC;
    localparam logic [3:0]  RSP_LAST    = 4'h3;
    localparam logic [1:0]  ORD_FIRST   = 2'd1;
    localparam logic [1:0]  ORD_INNER   = 2'd2;
    localparam logic [1:0]  ORD_LAST    = 2'd3;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam int          RSP_BYTES   = 4;

    // one byte of an MSB-first CRC-16 update
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pbs_crc16.sv
`timescale 1ns/1ps
module pbs_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_ld,
    input  logic        take,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import pbs_pkg::*;

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (seed_ld) begin
            crc_q <= CRC_SEED;
        end else if (take) begin
            crc_q <= crc16_step(crc_q, din);
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/pbs_segmenter.sv
`timescale 1ns/1ps
module pbs_segmenter #(
    parameter int LEN_W   = 20,
    parameter int SEL_W   = 3,
    parameter int LOG_MIN = 8,
    parameter int SEL_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] total_len,
    input  logic [SEL_W-1:0] pkt_sel,
    input  logic             pkt_open,
    input  logic             byte_take,
    output logic [1:0]       order,
    output logic             pkt_end,
    output logic             final_pkt
);
    import pbs_pkg::*;

    localparam int PKT_W = LOG_MIN + SEL_MAX + 1;
    localparam int CMP_W = (LEN_W > PKT_W) ? LEN_W : PKT_W;

    logic [CMP_W-1:0] rem_q, left_q, size_q;
    logic             first_q, final_q;
    logic [SEL_W-1:0] sel_eff;
    logic             fits;

    assign sel_eff = (pkt_sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : pkt_sel;
    assign fits    = (rem_q <= size_q);

    always_comb begin
        if (fits)         order = ORD_LAST;
        else if (first_q) order = ORD_FIRST;
        else              order = ORD_INNER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            left_q  <= '0;
            size_q  <= '0;
            first_q <= 1'b0;
            final_q <= 1'b0;
        end else if (load) begin
            rem_q   <= CMP_W'(total_len);
            size_q  <= CMP_W'(1) << (LOG_MIN + int'(sel_eff));
            left_q  <= '0;
            first_q <= 1'b1;
            final_q <= 1'b0;
        end else begin
            if (pkt_open) begin
                left_q  <= fits ? rem_q : size_q;
                first_q <= 1'b0;
                final_q <= fits;
            end
            if (byte_take) begin
                left_q <= left_q - CMP_W'(1);
                rem_q  <= rem_q - CMP_W'(1);
            end
        end
    end

    assign pkt_end   = (left_q == CMP_W'(1));
    assign final_pkt = final_q;
endmodule

// File: rtl/pbs_rsp_scan.sv
`timescale 1ns/1ps
module pbs_rsp_scan (
    input  logic [31:0] win,
    output logic        found,
    output logic        good
);
    import pbs_pkg::*;

    // later index wins: walk downward and keep the first hit
    always_comb begin
        found = 1'b0;
        good  = 1'b0;
        for (int i = RSP_BYTES - 2; i >= 0; i--) begin
            if (!found && (win[i*8+4 +: 4] == RSP_NIBBLE)) begin
                found = 1'b1;
                good  = (win[i*8 +: 4] == RSP_LAST) && (win[(i+1)*8 +: 8] == 8'h00);
            end
        end
    end
endmodule

// File: rtl/pkt_block_sender.sv
`timescale 1ns/1ps
module pkt_block_sender #(
    parameter int LEN_W   = 20,
    parameter int SEL_W   = 3,
    parameter int LOG_MIN = 8,
    parameter int SEL_MAX = 5,
    parameter int MIN_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [SEL_W-1:0] pkt_sel,
    input  logic             crc_en,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);
    import pbs_pkg::*;

    localparam int RIDX_W = $clog2(RSP_BYTES);

    pbs_state_e        state_q, state_d;
    pbs_status_e       status_q;
    logic              crc_on_q;
    logic [31:0]       rsp_q;
    logic [RIDX_W-1:0] ridx_q;

    logic        too_short, accept, take, pkt_open;
    logic [1:0]  order;
    logic        pkt_end, final_pkt;
    logic [15:0] crc;
    logic        scan_found, scan_good;

    assign too_short = (total_len < LEN_W'(MIN_LEN));
    assign accept    = (state_q == ST_IDLE) && start;
    assign take      = (state_q == ST_DATA) && in_valid && tx_ready;
    assign pkt_open  = (state_q == ST_TAG) && tx_ready;

    pbs_segmenter #(
        .LEN_W   (LEN_W),
        .SEL_W   (SEL_W),
        .LOG_MIN (LOG_MIN),
        .SEL_MAX (SEL_MAX)
    ) u_seg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && !too_short),
        .total_len (total_len),
        .pkt_sel   (pkt_sel),
        .pkt_open  (pkt_open),
        .byte_take (take),
        .order     (order),
        .pkt_end   (pkt_end),
        .final_pkt (final_pkt)
    );

    pbs_crc16 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_ld (state_q == ST_TAG),
        .take    (take),
        .din     (in_data),
        .crc     (crc)
    );

    pbs_rsp_scan u_scan (
        .win   (rsp_q),
        .found (scan_found),
        .good  (scan_good)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = too_short ? ST_REPORT : ST_TAG;
            ST_TAG:     if (tx_ready) state_d = ST_DATA;
            ST_DATA:    if (take && pkt_end) begin
                            if (crc_on_q)       state_d = ST_CRC_HI;
                            else if (final_pkt) state_d = ST_COLLECT;
                            else                state_d = ST_TAG;
                        end
            ST_CRC_HI:  if (tx_ready) state_d = ST_CRC_LO;
            ST_CRC_LO:  if (tx_ready) state_d = final_pkt ? ST_COLLECT : ST_TAG;
            ST_COLLECT: if (rx_valid && (ridx_q == RIDX_W'(RSP_BYTES - 1))) state_d = ST_EVAL;
            ST_EVAL:    state_d = ST_REPORT;
            ST_REPORT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STAT_OK;
            crc_on_q <= 1'b0;
            rsp_q    <= '0;
            ridx_q   <= '0;
        end else begin
            if (accept) begin
                crc_on_q <= crc_en;
                ridx_q   <= '0;
                if (too_short) status_q <= STAT_SHORT;
            end
            if ((state_q == ST_COLLECT) && rx_valid) begin
                rsp_q[ridx_q*8 +: 8] <= rx_data;
                ridx_q               <= ridx_q + RIDX_W'(1);
            end
            if (state_q == ST_EVAL) begin
                if (!scan_found)     status_q <= STAT_NO_START;
                else if (!scan_good) status_q <= STAT_BAD_RSP;
                else                 status_q <= STAT_OK;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        in_ready = 1'b0;
        rx_ready = 1'b0;
        busy     = (state_q != ST_IDLE);
        done     = 1'b0;
        unique case (state_q)
            ST_TAG: begin
                tx_valid = 1'b1;
                tx_data  = {TAG_NIBBLE, 2'b00, order};
            end
            ST_DATA: begin
                tx_valid = in_valid;
                tx_data  = in_data;
                in_ready = tx_ready;
            end
            ST_CRC_HI: begin
                tx_valid = 1'b1;
                tx_data  = crc[15:8];
            end
            ST_CRC_LO: begin
                tx_valid = 1'b1;
                tx_data  = crc[7:0];
            end
            ST_COLLECT: rx_ready = 1'b1;
            ST_REPORT:  done = 1'b1;
            default: ;
        endcase
    end

    assign status = status_q;
endmodule

// File: rtl/pbs_checker.sv
`timescale 1ns/1ps
module pbs_checker #(
    parameter int LEN_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LEN_W-1:0]   total_len,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [7:0]         tx_data,
    input logic               in_ready,
    input logic               busy,
    input logic               done,
    input logic [1:0]         status,
    input pbs_pkg::pbs_state_e state
);
    import pbs_pkg::*;

    // R2: a tag byte carries the tag nibble and a nonzero order code
    p_tag_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAG) |-> (tx_valid && tx_data[7:4] == 4'hF && tx_data[3:2] == 2'b00 && tx_data[1:0] != 2'b00));

    // R7: short payload gives done with status 1 in the next cycle
    p_short_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && total_len < LEN_W'(5)) |=> (done && status == 2'd1));

    // R11: done lasts one cycle and the engine is idle afterwards
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: a stalled non-payload byte stays put
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && state != ST_DATA) |=> (tx_valid && $stable(tx_data)));

    // R9: a start mid-transfer neither ends nor aborts it
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state inside {ST_TAG, ST_DATA, ST_CRC_HI, ST_CRC_LO}) |=> (busy && !done));

    // R7: no payload is drawn while idle
    p_idle_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !tx_valid));
endmodule

bind pkt_block_sender pbs_checker #(.LEN_W(LEN_W)) u_pbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .total_len (total_len),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .in_ready  (in_ready),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .state     (state_q)
);

// File: tb/pkt_block_sender_tb_top.sv
`timescale 1ns/1ps
module pkt_block_sender_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] total_len = '0;
    logic [2:0]  pkt_sel = '0;
    logic        crc_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        busy, done;
    logic [1:0]  status;

    always #5 clk = ~clk;

    pkt_block_sender dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .pkt_sel(pkt_sel), .crc_en(crc_en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .busy(busy), .done(done), .status(status)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pay [0:4095];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb = r[15] ^ b[k];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic void build_exp(input int len, input int sel, input bit crc);
        int psz = 256 << ((sel > 5) ? 5 : sel);
        int pos = 0;
        exp_q.delete();
        if (len < 5) return;
        while (pos < len) begin
            int n = ((len - pos) <= psz) ? (len - pos) : psz;
            logic [15:0] c = 16'hFFFF;
            if ((len - pos) <= psz) exp_q.push_back(8'hF3);
            else if (pos == 0)      exp_q.push_back(8'hF1);
            else                    exp_q.push_back(8'hF2);
            for (int j = 0; j < n; j++) begin
                exp_q.push_back(pay[pos + j]);
                c = ref_crc(c, pay[pos + j]);
            end
            if (crc) begin
                exp_q.push_back(c[15:8]);
                exp_q.push_back(c[7:0]);
            end
            pos += n;
        end
    endfunction

    function automatic int ref_status(input logic [31:0] r);
        for (int i = 2; i >= 0; i--) begin
            if (r[i*8+4 +: 4] == 4'hC)
                return ((r[i*8 +: 4] == 4'h3) && (r[(i+1)*8 +: 8] == 8'h00)) ? 0 : 3;
        end
        return 2;
    endfunction

    // reply window, byte 0 first
    function automatic logic [31:0] mk_rsp(input logic [7:0] b0, input logic [7:0] b1,
                                           input logic [7:0] b2, input logic [7:0] b3);
        return {b3, b2, b1, b0};
    endfunction

    task automatic run(input int len, input int sel, input bit crc,
                       input logic [31:0] rsp, input bit stray);
        int idx = 0;
        int ridx = 0;
        int cyc = 0;
        bit fin = 0;
        bit early = 0;
        bit last_busy = 0;
        int st = -1;
        bit st_lo;
        for (int i = 0; i < 4096; i++) pay[i] = 8'($urandom);
        build_exp(len, sel, crc);
        got_q.delete();
        while (!fin && cyc < 20000) begin
            @(negedge clk);
            st_lo = (cyc != 0) && stray && last_busy && ($urandom % 6 == 0);
            start     = (cyc == 0) || st_lo;
            total_len = st_lo ? 20'd3 : 20'(len);
            crc_en    = st_lo ? ~crc : crc;
            pkt_sel   = 3'(sel);
            in_valid  = (idx < len) && ($urandom % 4 != 0);
            in_data   = (idx < len && idx < 4096) ? pay[idx] : 8'h00;
            tx_ready  = ($urandom % 4 != 0);
            rx_valid  = (ridx < 4) && ($urandom % 2 == 0);
            rx_data   = (ridx < 4) ? rsp[ridx*8 +: 8] : 8'h00;
            #4;
            if (in_valid && in_ready) idx++;
            if (tx_valid && tx_ready) got_q.push_back(tx_data);
            if (rx_valid && rx_ready) begin
                if (got_q.size() < exp_q.size()) early = 1;
                ridx++;
            end
            last_busy = busy;
            if (done) begin fin = 1; st = int'(status); end
            cyc++;
        end
        @(negedge clk);
        start = 0; in_valid = 0; rx_valid = 0; tx_ready = 0;
        total_len = '0; crc_en = 0;
        chk("R11 transfer finished with done", int'(fin), 1);
        begin
            int mism = 0;
            int first = -1;
            if (got_q.size() != exp_q.size()) mism = 1;
            else for (int i = 0; i < exp_q.size(); i++)
                if (got_q[i] !== exp_q[i] && first < 0) begin first = i; mism = 1; end
            if (mism) $display("  stream len=%0d sel=%0d crc=%0d got %0d bytes exp %0d first bad idx %0d",
                               len, sel, crc, got_q.size(), exp_q.size(), first);
            // R1 R2 R3 R4 R9 R10: output byte sequence
            chk(crc ? "R1,R2,R3,R9,R10 byte stream mismatch" : "R1,R2,R4,R9,R10 byte stream mismatch", mism, 0);
        end
        chk("R1 payload bytes consumed", idx, (len < 5) ? 0 : len);
        chk("R5 reply bytes taken", ridx, (len < 5) ? 0 : 4);
        chk("R5 reply taken before final packet left", int'(early), 0);
        chk((len < 5) ? "R7 status" : "R6,R8 status", st, (len < 5) ? 1 : ref_status(rsp));
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] good;
        void'($urandom(32'h5EED_0C3A));
        good = mk_rsp(8'h00, 8'hC3, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        // reset state
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset done", int'(done), 0);
        chk("R7 reset tx_valid", int'(tx_valid), 0);
        chk("R5 reset rx_ready", int'(rx_ready), 0);
        chk("R8 reset status", int'(status), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed boundaries
        run(5,   0, 0, good, 0);                 // R1 smallest accepted
        run(4,   0, 1, good, 0);                 // R7 just below limit
        run(0,   0, 0, good, 0);                 // R7
        run(256, 0, 1, good, 0);                 // R1 exactly one packet
        run(257, 0, 1, good, 0);                 // R2 first + last of one byte
        run(768, 0, 1, good, 0);                 // R2 first, inner, last
        run(600, 7, 1, good, 0);                 // R1 select clamped to 8192
        run(700, 1, 0, good, 0);                 // R4 no CRC, 512-byte packets
        run(300, 0, 1, good, 1);                 // R9 stray start pulses
        // reply window cases (R6, R8)
        run(300, 0, 1, mk_rsp(8'hC2, 8'h00, 8'hC3, 8'h00), 0); // stale then good at 2
        run(300, 0, 0, mk_rsp(8'h11, 8'hC3, 8'h00, 8'h5A), 0); // good at 1
        run(300, 0, 1, mk_rsp(8'hC3, 8'h00, 8'h00, 8'h00), 0); // good at 0
        run(300, 0, 0, mk_rsp(8'h00, 8'h00, 8'h00, 8'h00), 0); // R8 no start
        run(300, 0, 1, mk_rsp(8'hC3, 8'h00, 8'hC2, 8'h00), 0); // R8 later bad wins
        run(300, 0, 0, mk_rsp(8'h00, 8'hC3, 8'h01, 8'h00), 0); // R8 nonzero state
        run(300, 0, 0, mk_rsp(8'h00, 8'h00, 8'h00, 8'hC3), 0); // R6 index 3 not scanned

        // random mix
        for (int t = 0; t < 30; t++) begin
            int len = 5 + int'($urandom % 900);
            int sel = ($urandom % 4 == 0) ? 7 : int'($urandom % 3);
            logic [31:0] r;
            case ($urandom % 4)
                0: r = good;
                1: r = $urandom;
                2: r = mk_rsp(8'hC2, 8'h00, 8'($urandom), 8'($urandom));
                default: r = mk_rsp(8'($urandom), 8'hC3, 8'($urandom % 2), 8'h00);
            endcase
            if (t % 7 == 0) len = 1 + int'($urandom % 4);
            run(len, sel, 1'($urandom), r, 1'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule